// File: doc/BRIEF.md
# Comma Word Aligner with Manual Realignment

This block sits right after the deserializer of a serial receiver. Each clock it takes a 20-bit parallel word whose bit boundary is arbitrary. Bit 0 of each word is the earliest bit received. The block keeps the previous word, so it can see a window that spans every one of the 20 possible bit offsets. It searches that window for a programmed alignment pattern. By default the pattern is the 20-bit pair of a negative-disparity K28.5 comma and a D10.2 symbol: 0xAA97C with bit 0 first on the line, so K28.5 (0x17C) fills the low ten bits.

After reset the aligner locks onto the first boundary where the pattern appears. It then holds that boundary against patterns at any other offset until the realign input shows a rising edge. It outputs the realigned 20-bit word one cycle after the input word, together with a flag for each 10-bit lane that holds the comma symbol. A sync flag rises once the pattern has been seen a second time at the held boundary.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted, and until data arrives after its release, `data_o`, `lane_comma_o` and `sync_o` are all zero.
- R2: One cycle after an input word W(t) is sampled, `data_o` holds bits [off, off+19] of the 39-bit stream {W(t)[18:0], W(t-1)}, where `off` is the held bit offset (0 after reset).
- R3: After reset, the first occurrence of the 20-bit pattern 0xAA97C at any offset sets the boundary, whatever level `realign_i` has. The word that carries it already comes out aligned, so `data_o` equals 0xAA97C.
- R4: Once a boundary is held, a pattern at any other offset does not change the boundary and does not change `sync_o`.
- R5: A rising edge on `realign_i` (sampled high after being sampled low) clears `sync_o` in the following cycle and returns the aligner to searching. A pattern in the same word as the edge is not used.
- R6: `sync_o` rises together with the aligned output of the second pattern found at the held boundary. It stays low after the first one.
- R7: `lane_comma_o[k]` is high with `data_o` when bits [10k+9:10k] of the aligned word equal the comma symbol 0x17C and a boundary is held.
- R8: Every offset from 0 to 19 can be locked and synchronised.
- R9: After a realign edge, the next pattern at any offset sets the new boundary. The word that carries it comes out aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive word clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 20 | Unaligned parallel word, bit 0 earliest |
| realign_i | input | 1 | Realign request, acts on its rising edge |
| data_o | output | 20 | Word realigned to the held boundary |
| lane_comma_o | output | 2 | Per 10-bit lane comma flag, same cycle as data_o |
| sync_o | output | 1 | Synchronisation status |

## Verification
On every cycle the assertions check four things. A first lock takes the lowest matching offset. The held offset never moves while a boundary is held. A realign edge drops sync at once. Sync can only rise out of the locked state. They also check that each lane flag matches the comma value on the data it accompanies. Other properties need whole scenarios and only the bench can show them: that a lock happens regardless of the realign level, that patterns at shifted offsets leave the boundary and sync alone, that each of the 20 offsets can be reached, and that sync waits for a second pattern.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LOCKED = 2'd1,
    ST_SYNCED = 2'd2
  } align_state_e;
endpackage

// File: rtl/cwa_rst_sync.sv
module cwa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cwa_window.sv
module cwa_window #(
  parameter int WORD_W = 20,
  localparam int WIN_W = 2 * WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic [WIN_W-1:0]  win_o
);
  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] prev_d;

  always_comb prev_d = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  // earliest bits in the low end: previous word, then current word
  assign win_o = {data_i[WORD_W-2:0], prev_q};
endmodule

// File: rtl/cwa_matcher.sv
module cwa_matcher #(
  parameter int WORD_W = 20,
  parameter int PAT_W  = 20,
  parameter logic [PAT_W-1:0] PATTERN = 20'hAA97C,
  localparam int WIN_W = 2 * WORD_W - 1,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_W-1:0]  win_i,
  output logic [WORD_W-1:0] match_o,
  output logic              found_o,
  output logic [OFF_W-1:0]  first_off_o
);
  genvar go;
  generate
    for (go = 0; go < WORD_W; go++) begin : g_cmp
      assign match_o[go] = (win_i[go +: PAT_W] == PATTERN);
    end
  endgenerate

  // lowest offset wins when several match in one window
  always_comb begin
    first_off_o = '0;
    for (int o = WORD_W - 1; o >= 0; o--) begin
      if (match_o[o]) first_off_o = OFF_W'(o);
    end
  end

  assign found_o = |match_o;

  // R3: the chosen offset is a match and nothing below it matched
  p_first_is_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (match_o[first_off_o] &&
                 ((match_o & ~({WORD_W{1'b1}} << first_off_o)) == '0)));
endmodule

// File: rtl/cwa_ctrl.sv
module cwa_ctrl
  import cwa_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int PAT_W  = 20,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              realign_i,
  input  logic [WORD_W-1:0] match_i,
  input  logic              found_i,
  input  logic [OFF_W-1:0]  first_off_i,
  output logic [OFF_W-1:0]  off_sel_o,
  output logic              bound_ok_o,
  output logic              sync_o
);
  align_state_e     state_q, state_d;
  logic [OFF_W-1:0] offset_q;
  logic             offset_en;
  logic             realign_q;
  logic             rl_edge;
  logic             lock_now;
  logic             hit_locked;

  assign rl_edge  = realign_i & ~realign_q;
  assign lock_now = (state_q == ST_SEARCH) && found_i && !rl_edge;

  // a match counts as "same boundary" when congruent modulo the pattern width
  always_comb begin
    hit_locked = 1'b0;
    for (int o = 0; o < WORD_W; o++) begin
      if ((o % PAT_W) == (int'(offset_q) % PAT_W)) hit_locked = hit_locked | match_i[o];
    end
  end

  always_comb begin
    state_d   = state_q;
    offset_en = lock_now;
    if (rl_edge) begin
      state_d = ST_SEARCH;
    end else begin
      unique case (state_q)
        ST_SEARCH: if (found_i)    state_d = ST_LOCKED;
        ST_LOCKED: if (hit_locked) state_d = ST_SYNCED;
        ST_SYNCED: state_d = ST_SYNCED;
        default:   state_d = ST_SEARCH;
      endcase
    end
  end

  assign off_sel_o  = lock_now ? first_off_i : offset_q;
  assign bound_ok_o = !rl_edge && ((state_q != ST_SEARCH) || found_i);
  assign sync_o     = (state_q == ST_SYNCED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SEARCH;
      realign_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      realign_q <= realign_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        offset_q <= '0;
    else if (offset_en) offset_q <= first_off_i;
  end

  // R3, R9: a pattern seen while searching locks that boundary
  p_lock_on_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && found_i && !rl_edge) |=>
      (state_q == ST_LOCKED && offset_q == $past(first_off_i)));

  // R4: the boundary never moves while one is held
  p_hold_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SEARCH) |=> $stable(offset_q));

  // R5: realign edge drops sync and reopens the search
  p_realign_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl_edge |=> (!sync_o && state_q == ST_SEARCH));

  // R6: sync only rises out of the locked state
  p_sync_after_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ($past(state_q) == ST_LOCKED));
endmodule

// File: rtl/cwa_shifter.sv
module cwa_shifter #(
  parameter int WORD_W = 20,
  parameter int SYM_W  = 10,
  parameter logic [SYM_W-1:0] COMMA = 10'h17C,
  localparam int WIN_W = 2 * WORD_W - 1,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int LANES = WORD_W / SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  off_sel_i,
  input  logic              bound_ok_i,
  output logic [WORD_W-1:0] data_o,
  output logic [LANES-1:0]  lane_comma_o
);
  logic [WORD_W-1:0] aligned;
  logic [LANES-1:0]  lane_hit;

  assign aligned = WORD_W'(win_i >> off_sel_i);

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign lane_hit[gl] = bound_ok_i && (aligned[gl*SYM_W +: SYM_W] == COMMA);

      // R7: a raised lane flag always travels with the comma in that lane
      p_flag_has_comma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lane_comma_o[gl] |-> (data_o[gl*SYM_W +: SYM_W] == COMMA));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= '0;
      lane_comma_o <= '0;
    end else begin
      data_o       <= aligned;
      lane_comma_o <= lane_hit;
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int WORD_W = 20,
  parameter int SYM_W  = 10,
  parameter int PAT_W  = 20,
  parameter logic [PAT_W-1:0] PATTERN = 20'hAA97C,
  parameter logic [SYM_W-1:0] COMMA   = 10'h17C,
  localparam int LANES = WORD_W / SYM_W,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int WIN_W = 2 * WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              realign_i,
  output logic [WORD_W-1:0] data_o,
  output logic [LANES-1:0]  lane_comma_o,
  output logic              sync_o
);
  logic              rst_n_s;
  logic [WIN_W-1:0]  win;
  logic [WORD_W-1:0] match;
  logic              found;
  logic [OFF_W-1:0]  first_off;
  logic [OFF_W-1:0]  off_sel;
  logic              bound_ok;

  cwa_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  cwa_window #(.WORD_W(WORD_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .data_i(data_i),
    .win_o (win)
  );

  cwa_matcher #(.WORD_W(WORD_W), .PAT_W(PAT_W), .PATTERN(PATTERN)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .win_i      (win),
    .match_o    (match),
    .found_o    (found),
    .first_off_o(first_off)
  );

  cwa_ctrl #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .realign_i  (realign_i),
    .match_i    (match),
    .found_i    (found),
    .first_off_i(first_off),
    .off_sel_o  (off_sel),
    .bound_ok_o (bound_ok),
    .sync_o     (sync_o)
  );

  cwa_shifter #(.WORD_W(WORD_W), .SYM_W(SYM_W), .COMMA(COMMA)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .win_i       (win),
    .off_sel_i   (off_sel),
    .bound_ok_i  (bound_ok),
    .data_o      (data_o),
    .lane_comma_o(lane_comma_o)
  );
endmodule

// File: tb/comma_word_aligner_bench.sv
`timescale 1ns/1ps
module comma_word_aligner_bench;
  localparam logic [19:0] PAT   = 20'hAA97C;
  localparam logic [9:0]  COMMA = 10'h17C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] din = '0;
  logic        realign = 1'b1;
  logic [19:0] dout;
  logic [1:0]  lane_flag;
  logic        sync;

  comma_word_aligner u_comma_word_aligner (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .realign_i(realign),
    .data_o(dout), .lane_comma_o(lane_flag), .sync_o(sync)
  );

  always #10 clk = ~clk;

  int  vectors = 0;
  int  fails   = 0;
  int  cycles  = 0;
  bit  bitq[$];
  int  fill_mode = 0;
  int  fill_ctr  = 0;
  bit  saw_pat, saw_f0, saw_f1;

  // reference model state
  int          m_state = 0;
  int          m_off   = 0;
  logic [19:0] m_prev  = '0;
  bit          m_rl    = 1'b1;
  logic [19:0] e_data  = '0;
  logic [1:0]  e_flag  = '0;
  bit          e_sync  = 1'b0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fill_bit();
    bit b;
    case (fill_mode)
      1:       b = fill_ctr[1];
      2:       b = fill_ctr[0];
      default: b = 1'b0;
    endcase
    fill_ctr++;
    return b;
  endfunction

  // behavioural model: stream window, search, hold, sync count
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_off = 0; m_prev = '0; m_rl = 1'b1;
      e_data = '0; e_flag = '0; e_sync = 1'b0;
    end else begin
      logic [38:0] w;
      bit found, valid, is_edge;
      int first, sel;
      w = {din[18:0], m_prev};
      found = 0; first = 0;
      for (int o = 19; o >= 0; o--)
        if (w[o +: 20] == PAT) begin found = 1; first = o; end
      is_edge = realign && !m_rl;
      sel = m_off;
      if (is_edge) begin
        m_state = 0; valid = 0;
      end else if (m_state == 0) begin
        valid = found;
        if (found) begin m_state = 1; m_off = first; sel = first; end
      end else begin
        valid = 1;
        if (m_state == 1 && w[m_off +: 20] == PAT) m_state = 2;
      end
      e_data = 20'(w >> sel);
      for (int k = 0; k < 2; k++)
        e_flag[k] = valid && (e_data[k*10 +: 10] == COMMA);
      e_sync = (m_state == 2);
      m_prev = din;
      m_rl = realign;
    end
  end

  // compare every cycle, then drive the next word
  always @(negedge clk) begin
    cycles++;
    check(dout == e_data, "R2 data", 32'(dout), 32'(e_data));
    check(sync == e_sync, "R6 sync", 32'(sync), 32'(e_sync));
    check(lane_flag == e_flag, "R7 lane flag", 32'(lane_flag), 32'(e_flag));
    if (dout == PAT) saw_pat = 1;
    if (lane_flag[0]) saw_f0 = 1;
    if (lane_flag[1]) saw_f1 = 1;
    while (bitq.size() < 20) bitq.push_back(fill_bit());
    for (int i = 0; i < 20; i++) din[i] = bitq.pop_front();
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic pad_word();
    while (bitq.size() % 20 != 0) bitq.push_back(fill_bit());
  endtask

  task automatic push_pat(int off);
    @(posedge clk);
    pad_word();
    for (int i = 0; i < off; i++) bitq.push_back(fill_bit());
    for (int i = 0; i < 20; i++) bitq.push_back(PAT[i]);
    pad_word();
  endtask

  task automatic push_comma(int off);
    @(posedge clk);
    pad_word();
    for (int i = 0; i < off; i++) bitq.push_back(fill_bit());
    for (int i = 0; i < 10; i++) bitq.push_back(COMMA[i]);
    pad_word();
  endtask

  task automatic drain();
    while (bitq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic pulse_realign();
    @(negedge clk); realign = 1'b0;
    @(negedge clk); realign = 1'b1;
    @(negedge clk); realign = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(dout == 20'h0 && lane_flag == 2'b0 && !sync, "R1 reset outputs",
          {dout, lane_flag, sync}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(dout == 20'h0 && !sync, "R1 after release", {dout, sync}, 32'h0);

    // R3: first lock with realign held high
    saw_pat = 0;
    push_pat(7); drain();
    check(saw_pat, "R3 first lock aligned", 32'(saw_pat), 1);
    check(!sync, "R6 no sync after first pattern", 32'(sync), 0);
    push_pat(7); drain();
    check(sync, "R6 sync after second pattern", 32'(sync), 1);
    @(negedge clk); realign = 1'b0;

    // R4: shifted pattern ignored
    saw_pat = 0; fill_mode = 1;
    push_pat(12); drain();
    check(!saw_pat, "R4 shifted pattern ignored", 32'(saw_pat), 0);
    check(sync, "R4 sync kept", 32'(sync), 1);

    for (int o = 0; o < 20; o++) begin
      fill_mode = o % 3;
      pulse_realign();
      check(!sync, "R5 sync cleared by realign", 32'(sync), 0);
      saw_pat = 0; saw_f0 = 0;
      push_pat(o); drain();
      check(saw_pat, "R9 new boundary aligned", 32'(saw_pat), 1);
      check(saw_f0, "R7 lane0 comma flag", 32'(saw_f0), 1);
      check(!sync, "R6 single pattern no sync", 32'(sync), 0);
      push_pat(o); drain();
      check(sync, "R8 offset locked and synced", 32'(sync), 1);
      if (o % 5 == 0) begin
        saw_pat = 0;
        push_pat((o + 3) % 20); drain();
        check(!saw_pat && sync, "R4 other offset ignored", {saw_pat, sync}, 32'h1);
      end
      saw_f1 = 0;
      push_comma((o + 10) % 20); drain();
      check(saw_f1, "R7 lane1 comma flag", 32'(saw_f1), 1);
    end

    finish_run();
  end
endmodule